// File: doc/BRIEF.md
# AC-Link Codec Status and GPIO Slot Controller

This block connects a small 32-bit register port to the serial link of an audio codec. On the receive side it watches each 256-bit frame and keeps three things: the address and data of the last codec register read-back, and the state of the codec's general-purpose pins. On the transmit side it places host-written pin data into the last slot of every outgoing frame. A few control bits set the frame sync line, allow a second codec data input, and choose slot numbers for two audio channels. A level interrupt request signals pin changes and codec interrupt flags.

A frame has 256 bit times. It begins with a 16-bit tag slot and is followed by twelve 20-bit slots. All fields are sent most significant bit first. The bit clock is sampled by the system clock, which must run at least four times faster. A rising bit clock launches an output bit. A falling bit clock samples an input bit. A frame begins at the first rising bit clock that sees the sync output high after it was low. After that, frames follow one another every 256 bits. Frame bit index i holds tag bit 15-i for i below 16. Tag bit 15 is codec ready, and tag bit 15-s marks slot s as valid. Slot s occupies indices 16+20(s-1) to 16+20s-1.

Top module: `aclink_slot_ctrl`

## Requirements
- R1: With the pin interface enabled (word 0x00 bit 31), a frame whose codec-ready and slot-12 tag bits are both 1 loads slot 12 into word 0x00 bits [19:0]. While the interface is disabled, those bits and bit 20 keep their value.
- R2: Word 0x04 bits [19:0] are sent in output slot 12, MSB first, at indices 236..255. Output tag bits 15 and 3 (indices 0 and 12) carry the interface enable. Every other output bit is 0. With the interface disabled the whole output frame is 0.
- R3: Word 0x08 bits [31:24] show bits [19:12] of input slot 1, and bits [15:0] show bits [19:4] of input slot 2. Both update only at the end of a frame whose ready, slot-1 and slot-2 tag bits are all 1.
- R4: Word 0x08 bit 17 reads 1 after a frame in which ready, slot-1 and slot-2 tag bits were all 1. It reads 0 after any other frame.
- R5: Word 0x00 bit 20 reads 0 after an enabled frame whose ready and slot-12 tag bits are both 1, and reads 1 after an enabled frame where either is 0.
- R6: Bits are launched on the rising bit clock and sampled on the falling bit clock. Frame index 0 is the first rising bit clock that sees sync high after it was low, and this restarts the frame even in mid-frame. The index then wraps from 255 to 0.
- R7: The sync output equals word 0x08 bit 22.
- R8: With word 0x08 bit 21 at 0, the second serial input is ignored. With it at 1, the received bit is the OR of both inputs.
- R9: Word 0x08 bit 20 sets the receive channel slot output and bit 19 sets the transmit channel slot output. The value 0 gives slot 6 and 1 gives slot 11.
- R10: Word 0x0C bit 0 becomes pending when an enabled frame changes the captured pins and word 0x00 bit 30 is 1. Bit 1 becomes pending when a frame with valid ready and slot-12 tag bits carries slot-12 bit 0 set and word 0x08 bit 23 is 1. Writing 1 clears a pending bit. The interrupt output is the OR of the pending bits.
- R11: All words reset to 0x00000000. Bits with no function read 0 and ignore writes. A word address with bits [1:0] not 00 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Byte address of the register word |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| bclk_i | input | 1 | Serial bit clock from the codec |
| sdin_i | input | 1 | Primary serial data from the codec |
| sdin2_i | input | 1 | Second serial data input |
| sync_o | output | 1 | Frame sync to the codec |
| sdout_o | output | 1 | Serial data to the codec |
| irq_o | output | 1 | Level interrupt request |
| rx_slot_o | output | 4 | Slot number selected for the receive channel |
| tx_slot_o | output | 4 | Slot number selected for the transmit channel |

## Verification
The bench sweeps the tag-bit combinations so that each of ready, slot 1, slot 2 and slot 12 is missing in some frame. A design that qualified the status on fewer tag bits would update the address and data, or set the tag bit, on partial frames. A design with the valid polarity the wrong way round would report invalid pin captures as valid. The bench also holds the second input high while it is disabled, turns the pin interface off, and raises sync again in mid-frame. An OR that is not gated would corrupt every capture. A missing enable gate would overwrite the pin status or drive slot 12. A counter that ignored the new sync edge would sample the next frame off by 40 bits. Pending bits are set, read and cleared again, and frames with identical pin data are included, to show that an unchanged capture raises no request.

// File: rtl/aclink_pkg.sv
// Shared constants for the codec serial link slot controller.
// Assumes a fixed frame of one tag slot followed by equal data slots.
package aclink_pkg;
    localparam int TAG_BITS   = 16;
    localparam int SLOT_BITS  = 20;
    localparam int NUM_SLOTS  = 12;
    localparam int FRAME_BITS = TAG_BITS + SLOT_BITS * NUM_SLOTS;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int POS_W      = $clog2(SLOT_BITS);
    localparam int ADDR_BITS  = 8;
    localparam int DATA_BITS  = 16;
    // last frame index of data slot s (1-based)
    localparam int LAST_S1    = TAG_BITS + SLOT_BITS * 1 - 1;
    localparam int LAST_S2    = TAG_BITS + SLOT_BITS * 2 - 1;
    localparam int LAST_PINS  = TAG_BITS + SLOT_BITS * NUM_SLOTS - 1;
    localparam int FIRST_PINS = LAST_PINS - SLOT_BITS + 1;
    // tag bit 15-s sits at frame index s
    localparam int TIDX_READY = 0;
    localparam int TIDX_S1    = 1;
    localparam int TIDX_S2    = 2;
    localparam int TIDX_PINS  = NUM_SLOTS;
    localparam logic [3:0] SLOT_DEF = 4'd6;
    localparam logic [3:0] SLOT_ALT = 4'd11;
    localparam logic [1:0] W_PSTAT = 2'd0;
    localparam logic [1:0] W_PCTRL = 2'd1;
    localparam logic [1:0] W_CSTAT = 2'd2;
    localparam logic [1:0] W_IRQ   = 2'd3;
endpackage

// File: rtl/ac_frame_timer.sv
// Detects bit clock edges in the system clock domain and keeps the frame
// bit index. Assumes the system clock runs at least 4x the bit clock.
// Index 0 is forced at the first rising bit clock that sees sync high
// after it was low; otherwise the index advances and wraps.
module ac_frame_timer
    import aclink_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_i,
    input  logic             sync_i,
    output logic             rise_o,
    output logic             fall_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [IDX_W-1:0] idx_next_o
);
    logic bclk_q;
    logic sync_seen;

    // previous bit clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_q <= 1'b0;
        else        bclk_q <= bclk_i;
    end

    assign rise_o = bclk_i & ~bclk_q;
    assign fall_o = ~bclk_i & bclk_q;

    always_comb begin
        if (sync_i && !sync_seen)               idx_next_o = '0;
        else if (idx_o == IDX_W'(FRAME_BITS-1)) idx_next_o = '0;
        else                                    idx_next_o = idx_o + 1'b1;
    end

    // frame index and sync level seen at the last rising bit clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_o     <= '0;
            sync_seen <= 1'b0;
        end else if (rise_o) begin
            idx_o     <= idx_next_o;
            sync_seen <= sync_i;
        end
    end

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_o |=> $stable(idx_o)); // R6
    AST_SYNC_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o && sync_i && !sync_seen) |=> (idx_o == '0)); // R6
endmodule

// File: rtl/ac_rx_capture.sv
// Samples incoming frame bits on the falling bit clock and commits the
// codec status and pin capture at the last bit of the frame.
// Assumes the tag bits of a frame arrive before its last bit.
module ac_rx_capture
    import aclink_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fall_i,
    input  logic [IDX_W-1:0]     idx_i,
    input  logic                 din_i,
    input  logic                 pins_en_i,
    output logic [ADDR_BITS-1:0] st_addr_o,
    output logic [DATA_BITS-1:0] st_data_o,
    output logic                 st_new_o,
    output logic [SLOT_BITS-1:0] pins_o,
    output logic                 pins_bad_o,
    output logic                 ev_pins_o,
    output logic                 ev_int_o
);
    logic [SLOT_BITS-1:0] shift_q;
    logic [SLOT_BITS-1:0] word;
    logic                 t_rdy, t_s1, t_s2, t_pins;
    logic [ADDR_BITS-1:0] addr_tmp;
    logic [DATA_BITS-1:0] data_tmp;
    logic                 frame_end, stat_ok, pins_ok;

    assign word      = {shift_q[SLOT_BITS-2:0], din_i};
    assign frame_end = fall_i && (idx_i == IDX_W'(LAST_PINS));
    assign stat_ok   = t_rdy & t_s1 & t_s2;
    assign pins_ok   = t_rdy & t_pins;

    // slot shifter, tag bits and slot 1/2 holding fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q  <= '0;
            t_rdy    <= 1'b0;
            t_s1     <= 1'b0;
            t_s2     <= 1'b0;
            t_pins   <= 1'b0;
            addr_tmp <= '0;
            data_tmp <= '0;
        end else if (fall_i) begin
            shift_q <= word;
            if (idx_i == IDX_W'(TIDX_READY)) t_rdy  <= din_i;
            if (idx_i == IDX_W'(TIDX_S1))    t_s1   <= din_i;
            if (idx_i == IDX_W'(TIDX_S2))    t_s2   <= din_i;
            if (idx_i == IDX_W'(TIDX_PINS))  t_pins <= din_i;
            if (idx_i == IDX_W'(LAST_S1))
                addr_tmp <= word[SLOT_BITS-1 -: ADDR_BITS];
            if (idx_i == IDX_W'(LAST_S2))
                data_tmp <= word[SLOT_BITS-1 -: DATA_BITS];
        end
    end

    // codec status commit at frame end, qualified by the tag bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_addr_o <= '0;
            st_data_o <= '0;
            st_new_o  <= 1'b0;
        end else if (frame_end) begin
            st_new_o <= stat_ok;
            if (stat_ok) begin
                st_addr_o <= addr_tmp;
                st_data_o <= data_tmp;
            end
        end
    end

    // pin capture, inverted valid flag and event pulses at frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_o     <= '0;
            pins_bad_o <= 1'b0;
            ev_pins_o  <= 1'b0;
            ev_int_o   <= 1'b0;
        end else begin
            ev_pins_o <= 1'b0;
            ev_int_o  <= 1'b0;
            if (frame_end) begin
                ev_int_o <= pins_ok & word[0];
                if (pins_en_i) begin
                    pins_bad_o <= ~pins_ok;
                    if (pins_ok) begin
                        pins_o    <= word;
                        ev_pins_o <= (word != pins_o);
                    end
                end
            end
        end
    end

    AST_STATUS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(st_addr_o) && $stable(st_data_o))); // R3
    AST_TAG_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(st_new_o)); // R4
    AST_PINS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !pins_en_i |=> ($stable(pins_o) && $stable(pins_bad_o))); // R1
endmodule

// File: rtl/ac_tx_insert.sv
// Launches the outgoing frame bit on each rising bit clock: enable in tag
// bits 15 and 3, host pin data in slot 12, zero elsewhere.
// Assumes the pin data is held stable while a frame is sent.
module ac_tx_insert
    import aclink_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rise_i,
    input  logic [IDX_W-1:0]     idx_next_i,
    input  logic                 pins_en_i,
    input  logic [SLOT_BITS-1:0] pins_i,
    output logic                 sdout_o
);
    logic [IDX_W-1:0] back;
    logic             bit_val;

    assign back = IDX_W'(FRAME_BITS-1) - idx_next_i;

    always_comb begin
        bit_val = 1'b0;
        if (idx_next_i == IDX_W'(TIDX_READY) || idx_next_i == IDX_W'(TIDX_PINS))
            bit_val = pins_en_i;
        else if (idx_next_i >= IDX_W'(FIRST_PINS))
            bit_val = pins_en_i & pins_i[back[POS_W-1:0]];
    end

    // output bit register, updated at rising bit clock only
    always_ff @(posedge clk) begin
        if (!rst_n)      sdout_o <= 1'b0;
        else if (rise_i) sdout_o <= bit_val;
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_i |=> $stable(sdout_o)); // R6
    AST_TX_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !pins_en_i) |=> !sdout_o); // R2
endmodule

// File: rtl/aclink_slot_ctrl.sv
// Register front end of the codec link slot controller. Holds the
// control bits and pending flags, decodes the word-aligned register port
// and instantiates the frame timer, receive capture and transmit insert.
// Assumes a single clock domain; reads are combinational.
module aclink_slot_ctrl
    import aclink_pkg::*;
#(
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              bclk_i,
    input  logic              sdin_i,
    input  logic              sdin2_i,
    output logic              sync_o,
    output logic              sdout_o,
    output logic              irq_o,
    output logic [3:0]        rx_slot_o,
    output logic [3:0]        tx_slot_o
);
    logic                 pins_en, pins_irq_en, int_en, in2_en, rx_sel, tx_sel;
    logic [SLOT_BITS-1:0] pins_out;
    logic                 pend_pins, pend_int;
    logic                 aligned;
    logic [1:0]           wsel;
    logic                 wr_ps, wr_pc, wr_cs, wr_irq;
    logic                 rise, fall, din;
    logic [IDX_W-1:0]     idx, idx_next;
    logic [ADDR_BITS-1:0] st_addr;
    logic [DATA_BITS-1:0] st_data;
    logic                 st_new, pins_bad, ev_pins, ev_int;
    logic [SLOT_BITS-1:0] pins_in;

    assign aligned = (reg_addr[1:0] == 2'b00);
    assign wsel    = reg_addr[3:2];
    assign wr_ps   = reg_wr && aligned && (wsel == W_PSTAT);
    assign wr_pc   = reg_wr && aligned && (wsel == W_PCTRL);
    assign wr_cs   = reg_wr && aligned && (wsel == W_CSTAT);
    assign wr_irq  = reg_wr && aligned && (wsel == W_IRQ);
    assign din     = sdin_i | (in2_en & sdin2_i);

    // writable control fields; reserved bits are dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_en     <= 1'b0;
            pins_irq_en <= 1'b0;
            pins_out    <= '0;
            int_en      <= 1'b0;
            sync_o      <= 1'b0;
            in2_en      <= 1'b0;
            rx_sel      <= 1'b0;
            tx_sel      <= 1'b0;
        end else begin
            if (wr_ps) {pins_en, pins_irq_en} <= reg_wdata[31:30];
            if (wr_pc) pins_out <= reg_wdata[SLOT_BITS-1:0];
            if (wr_cs) {int_en, sync_o, in2_en, rx_sel, tx_sel} <= reg_wdata[23:19];
        end
    end

    // pending flags: set by enabled events, cleared by writing 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_pins <= 1'b0;
            pend_int  <= 1'b0;
        end else begin
            pend_pins <= (pend_pins & ~(wr_irq & reg_wdata[0])) | (ev_pins & pins_irq_en);
            pend_int  <= (pend_int  & ~(wr_irq & reg_wdata[1])) | (ev_int & int_en);
        end
    end

    assign irq_o     = pend_pins | pend_int;
    assign rx_slot_o = rx_sel ? SLOT_ALT : SLOT_DEF;
    assign tx_slot_o = tx_sel ? SLOT_ALT : SLOT_DEF;

    // read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            case (wsel)
                W_PSTAT: reg_rdata = {pins_en, pins_irq_en, 9'd0, pins_bad, pins_in};
                W_PCTRL: reg_rdata = {12'd0, pins_out};
                W_CSTAT: reg_rdata = {st_addr, int_en, sync_o, in2_en, rx_sel, tx_sel,
                                      1'b0, st_new, 1'b0, st_data};
                default: reg_rdata = {30'd0, pend_int, pend_pins};
            endcase
        end
    end

    ac_frame_timer u_timer (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .sync_i(sync_o),
        .rise_o(rise), .fall_o(fall), .idx_o(idx), .idx_next_o(idx_next)
    );

    ac_rx_capture u_rx (
        .clk(clk), .rst_n(rst_n), .fall_i(fall), .idx_i(idx), .din_i(din),
        .pins_en_i(pins_en), .st_addr_o(st_addr), .st_data_o(st_data),
        .st_new_o(st_new), .pins_o(pins_in), .pins_bad_o(pins_bad),
        .ev_pins_o(ev_pins), .ev_int_o(ev_int)
    );

    ac_tx_insert u_tx (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .idx_next_i(idx_next),
        .pins_en_i(pins_en), .pins_i(pins_out), .sdout_o(sdout_o)
    );

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !wr_irq) |=> irq_o); // R10
    AST_SYNC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cs |=> (sync_o == $past(reg_wdata[22]))); // R7
endmodule

// File: tb/test_aclink_slot_ctrl.sv
`timescale 1ns/1ps
module test_aclink_slot_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bclk = 1'b0, sdin = 1'b0, sdin2 = 1'b0;
    logic        sync, sdout, irq;
    logic [3:0]  rxs, txs;

    int n_vec = 0;
    int n_bad = 0;

    // model state
    logic        m_en = 0, m_smi = 0, m_ser = 0, m_sync = 0, m_sd2 = 0, m_rxs = 0, m_txs = 0;
    logic [19:0] m_gdata = '0;
    logic [7:0]  e_addr = '0;
    logic [15:0] e_data = '0;
    logic        e_new = 0, e_nv = 0, e_pg = 0, e_ps = 0;
    logic [19:0] e_gpio = '0;
    logic        junk2 = 1'b0;

    always #5 clk = ~clk;

    aclink_slot_ctrl i_aclink_slot_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bclk_i(bclk),
        .sdin_i(sdin), .sdin2_i(sdin2), .sync_o(sync), .sdout_o(sdout),
        .irq_o(irq), .rx_slot_o(rxs), .tx_slot_o(txs)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_frame(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_cfg();
        wr(4'h8, {8'd0, m_ser, m_sync, m_sd2, m_rxs, m_txs, 19'd0});
    endtask

    // one bit period: rise, hold, fall, hold; sdout sampled at period end
    task automatic drive_bit(input logic b, input logic b2, output logic so);
        @(negedge clk);
        bclk = 1'b1; sdin = b; sdin2 = b2;
        repeat (4) @(negedge clk);
        bclk = 1'b0;
        repeat (4) @(negedge clk);
        so = sdout;
    endtask

    task automatic run_frame(input logic [15:0] tag, input logic [19:0] s1, input logic [19:0] s2,
                             input logic [19:0] s12, input logic use2, output logic [255:0] txv);
        logic [255:0] fr;
        logic so;
        fr = {tag, s1, s2, 180'd0, s12};
        for (int i = 0; i < 256; i++) begin
            if (use2) drive_bit(1'b0, fr[255-i], so);
            else      drive_bit(fr[255-i], junk2, so);
            txv[255-i] = so;
        end
    endtask

    task automatic model(input logic [15:0] tag, input logic [19:0] s1, input logic [19:0] s2,
                         input logic [19:0] s12);
        logic r, a, b, t;
        r = tag[15]; a = tag[14]; b = tag[13]; t = tag[3];
        e_new = r & a & b;
        if (e_new) begin e_addr = s1[19:12]; e_data = s2[19:4]; end
        if (m_en) begin
            e_nv = ~(r & t);
            if (r & t) begin
                if (s12 != e_gpio && m_smi) e_pg = 1'b1;
                e_gpio = s12;
            end
        end
        if (r & t & s12[0] & m_ser) e_ps = 1'b1;
    endtask

    task automatic check_all(input string tagname, input logic [255:0] txv);
        logic [31:0] d;
        logic [255:0] exp_tx;
        exp_tx = {(m_en ? 16'h8008 : 16'h0), 220'd0, (m_en ? m_gdata : 20'd0)};
        chk_frame({"R2 R6 tx frame ", tagname}, txv, exp_tx);
        rd(4'h8, d);
        chk({"R3 R4 status word ", tagname}, d,
            {e_addr, m_ser, m_sync, m_sd2, m_rxs, m_txs, 1'b0, e_new, 1'b0, e_data});
        rd(4'h0, d);
        chk({"R1 R5 pin status word ", tagname}, d, {m_en, m_smi, 9'd0, e_nv, e_gpio});
        rd(4'hC, d);
        chk({"R10 pending word ", tagname}, d, {30'd0, e_ps, e_pg});
        chk({"R10 irq ", tagname}, {31'd0, irq}, {31'd0, e_pg | e_ps});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [255:0] txv;
        logic [15:0] tag;
        logic [19:0] s1, s2, s12;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset values
        for (int a = 0; a < 16; a += 4) begin
            rd(4'(a), d);
            chk("R11 reset word", d, 32'h0);
        end
        chk("R11 reset irq/sync/sdout", {29'd0, irq, sync, sdout}, 32'h0);
        chk("R9 reset slots", {24'd0, rxs, txs}, 32'h66);

        // R11 reserved bits and misaligned access
        wr(4'h0, 32'h3FFF_FFFF); rd(4'h0, d); chk("R11 reserved in word 0", d, 32'h0);
        wr(4'h4, 32'hFFFF_FFFF); rd(4'h4, d); chk("R11 pin data field", d, 32'h000F_FFFF);
        m_gdata = 20'hFFFFF;
        wr(4'h5, 32'h0); rd(4'h4, d); chk("R11 misaligned write ignored", d, 32'h000F_FFFF);
        rd(4'h5, d); chk("R11 misaligned read", d, 32'h0);
        wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, d); chk("R11 ctrl field", d, 32'h00F8_0000);
        chk("R7 sync high", {31'd0, sync}, 32'd1);
        chk("R9 both slot 11", {24'd0, rxs, txs}, 32'hBB);
        wr(4'h8, 32'h0010_0000);
        chk("R9 rx 11 tx 6", {24'd0, rxs, txs}, 32'hB6);
        chk("R7 sync low", {31'd0, sync}, 32'd0);
        wr(4'h8, 32'h0008_0000);
        chk("R9 rx 6 tx 11", {24'd0, rxs, txs}, 32'h6B);
        wr(4'hC, 32'hFFFF_FFFF); rd(4'hC, d); chk("R10 nothing pending", d, 32'h0);

        // enable interface, pin and serial interrupts, raise sync
        m_en = 1; m_smi = 1;
        wr(4'h0, 32'hC000_0000);
        m_ser = 1; m_sync = 1; m_sd2 = 0; m_rxs = 0; m_txs = 0;
        set_cfg();

        // sweep tag combinations with arithmetic payloads
        for (int k = 0; k < 16; k++) begin
            m_gdata = 20'(k * 32'h1F0F3 + 5);
            wr(4'h4, {12'd0, m_gdata});
            tag = 16'h0;
            tag[15] = k[0]; tag[14] = k[1]; tag[13] = k[2]; tag[3] = k[3] | k[0];
            s1  = {8'(k * 37 + 1), 12'hABC};
            s2  = {16'(k * 4369) ^ 16'hA5C3, 4'h9};
            s12 = 20'(k * 32'h11111) ^ 20'(k >> 1);
            if (k == 13) s12 = e_gpio;   // unchanged pins: no event
            run_frame(tag, s1, s2, s12, 1'b0, txv);
            model(tag, s1, s2, s12);
            check_all($sformatf("sweep %0d", k), txv);
            if (k[1]) begin
                wr(4'hC, 32'h3);
                e_pg = 0; e_ps = 0;
                chk("R10 cleared by write", {31'd0, irq}, 32'd0);
            end
        end
        wr(4'hC, 32'h3); e_pg = 0; e_ps = 0;

        // R1 R2 interface disabled: pins frozen, output silent
        m_en = 0;
        wr(4'h0, 32'h4000_0000);
        m_gdata = 20'h12345;
        wr(4'h4, {12'd0, m_gdata});
        run_frame(16'hE008, 20'h5A000, 20'h13570, 20'hABCDE, 1'b0, txv);
        model(16'hE008, 20'h5A000, 20'h13570, 20'hABCDE);
        check_all("disabled", txv);

        // R8 second input ignored while disabled
        m_en = 1;
        wr(4'h0, 32'hC000_0000);
        junk2 = 1'b1;
        run_frame(16'hE008, 20'h3C000, 20'h2468A, 20'h0F0F1, 1'b0, txv);
        model(16'hE008, 20'h3C000, 20'h2468A, 20'h0F0F1);
        check_all("R8 sdin2 disabled", txv);
        junk2 = 1'b0;
        wr(4'hC, 32'h3); e_pg = 0; e_ps = 0;

        // R8 second input used when enabled
        m_sd2 = 1; set_cfg();
        run_frame(16'hE008, 20'h77000, 20'hFEDC0, 20'h80002, 1'b1, txv);
        model(16'hE008, 20'h77000, 20'hFEDC0, 20'h80002);
        check_all("R8 sdin2 enabled", txv);
        m_sd2 = 0; set_cfg();
        wr(4'hC, 32'h3); e_pg = 0; e_ps = 0;

        // R6 restart in mid-frame on a new sync rise
        for (int i = 0; i < 37; i++) drive_bit(1'b1, 1'b0, txv[0]);
        m_sync = 0; set_cfg();
        for (int i = 0; i < 3; i++) drive_bit(1'b1, 1'b0, txv[0]);
        m_sync = 1; set_cfg();
        run_frame(16'hE008, 20'h91000, 20'h0BEE0, 20'h00440, 1'b0, txv);
        model(16'hE008, 20'h91000, 20'h0BEE0, 20'h00440);
        check_all("R6 resync", txv);

        summary();
        $finish;
    end
endmodule